// File: doc/BRIEF.md
# Video Encoder Configuration Bus Slave

This block is a two-wire serial bus slave that loads the configuration of a video encoder. It samples the bus clock and data lines with the system clock and finds the bus conditions from them. It pulls the data line low only through an open-drain enable. An input pin picks one of two 7-bit device addresses. A write places the first byte after the address into a register pointer and stores each later byte at that pointer, then advances the pointer. A read has no pointer phase. It streams bytes out from wherever the pointer stands.

The stored settings appear as parallel outputs and feed the encoder datapath directly:
- a 14-bit wide-screen signalling word with its output enable;
- colour-burst start and end positions;
- a colour-detection enable and a field-sequence source select for the real-time control input.

Top module: `vid_enc_i2c_slave`

## Requirements
- R1: With `addr_sel`=0 the slave answers device address 44h. With `addr_sel`=1 it answers 46h. The address byte is the 7-bit address followed by a direction bit (0 = write, 1 = read), so the write bytes are 88h and 8Ch and the read bytes are 89h and 8Dh. The slave acknowledges a matching address by pulling SDA low during the ninth clock.
- R2: A non-matching address gets no acknowledge. Every later byte of that transfer is ignored: it is not acknowledged and changes no register. This lasts until the next START or STOP.
- R3: In a write, the byte after the address loads the register pointer. Each following byte is stored at the pointer. The slave acknowledges the pointer byte and every data byte.
- R4: The pointer advances by one after every data byte written or read, and it wraps from FFh to 00h.
- R5: A read takes no pointer byte. It returns the register at the current pointer, MSB first, and continues with the next register for as long as the master acknowledges.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R7: After reset:
  - the signalling word is 0 and its enable is 0;
  - burst start is 33 and burst end is 29;
  - colour-detection enable and field-sequence select are 0.
- R8: The register layout is:
  - 26h holds signalling bits 7:0 (bits 3:0 aspect ratio, 7:4 enhanced services).
  - 27h holds bit 7 = signalling enable and bits 5:0 = signalling bits 13:8 (bits 10:8 subtitles, 13:11 reserved).
  - 28h holds bit 6 = colour-detection enable and bits 5:0 = burst start.
  - 29h holds bit 6 = field-sequence select and bits 5:0 = burst end.
  - Unused bits read as 0.
- R9: A START, including a repeated START, restarts address matching. A STOP returns the slave to idle with SDA released.
- R10: A write to any other subaddress changes no output, and a read of one returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Device address select: 0 = 44h, 1 = 46h |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| wss_word | output | 14 | Wide-screen signalling word |
| wss_enable | output | 1 | Signalling output enable |
| burst_start | output | 6 | Colour-burst start position in clocks |
| burst_end | output | 6 | Colour-burst end position in clocks |
| colour_det_en | output | 1 | Use the colour-detection bit of the real-time control input |
| field_seq_sel | output | 1 | Field sequence taken from the real-time control input |

## Verification
Two events land on the same system-clock cycle: the store of a written byte and the pointer advance. Both happen on the SCL fall that ends the eighth data bit.

The bench provokes this in two ways:
- a multi-byte write that crosses 28h, 29h and the unmapped 2Ah;
- a long write that starts at FFh and runs through the wrap to 00h and on to 26h and 27h.

It judges the result by checking that each byte lands in the register named by the old pointer and that the next byte lands one place further. It does this through the parallel outputs and through a read that carries no pointer byte.

// File: rtl/vid_i2c_pkg.sv
package vid_i2c_pkg;

    localparam int PTR_W       = 8;
    localparam int WSS_W       = 14;
    localparam int BURST_W     = 6;
    localparam int BIT_CNT_W   = 4;

    localparam logic [PTR_W-1:0] SUB_WSS_LO = 8'h26;
    localparam logic [PTR_W-1:0] SUB_WSS_HI = 8'h27;
    localparam logic [PTR_W-1:0] SUB_BST    = 8'h28;
    localparam logic [PTR_W-1:0] SUB_BEN    = 8'h29;

    localparam logic [BURST_W-1:0] BURST_START_RST = 6'd33;
    localparam logic [BURST_W-1:0] BURST_END_RST   = 6'd29;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RMACK,
        ST_IGNORE
    } bus_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic [WSS_W-1:0]   wss;
        logic               wss_en;
        logic [BURST_W-1:0] burst_start;
        logic [BURST_W-1:0] burst_end;
        logic               colour_det_en;
        logic               field_seq_sel;
    } vid_cfg_t;

    function automatic logic is_mapped(input logic [PTR_W-1:0] a);
        return (a == SUB_WSS_LO) || (a == SUB_WSS_HI) ||
               (a == SUB_BST)    || (a == SUB_BEN);
    endfunction

    function automatic logic may_drive(input bus_state_e s);
        return (s == ST_ADDR_ACK) || (s == ST_SUB_ACK) ||
               (s == ST_WDATA_ACK) || (s == ST_RDATA);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import vid_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_q;
    logic [TOP:0] sda_q;
    logic         scl_d;
    logic         sda_d;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[TOP-1:0], scl_in};
                    sda_q <= {sda_q[TOP-1:0], sda_in};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_in;
                    sda_q <= sda_in;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q[TOP];
            sda_d <= sda_q[TOP];
        end
    end

    always_comb begin
        evt.scl_rise = scl_q[TOP] & ~scl_d;
        evt.scl_fall = ~scl_q[TOP] & scl_d;
        evt.start    = scl_q[TOP] & scl_d & sda_d & ~sda_q[TOP];
        evt.stop     = scl_q[TOP] & scl_d & ~sda_d & sda_q[TOP];
        evt.sda      = sda_q[TOP];
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import vid_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR_A = 7'h44,
    parameter logic [6:0] DEV_ADDR_B = 7'h46
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic             addr_sel,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    bus_state_e           state;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [7:0]           shreg;
    logic                 rnw;
    logic                 nack;
    logic                 byte_end;
    logic [6:0]           my_addr;

    always_comb begin
        my_addr  = addr_sel ? DEV_ADDR_B : DEV_ADDR_A;
        byte_end = evt.scl_fall && (bitcnt == BIT_CNT_W'(8));
        wr_en    = (state == ST_WDATA) && byte_end;
        wr_data  = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            ptr    <= '0;
            rnw    <= 1'b0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (evt.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (evt.scl_rise) begin
                        shreg  <= {shreg[6:0], evt.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == my_addr) begin
                                rnw    <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end else if (state == ST_SUB) begin
                            ptr    <= shreg;
                            sda_oe <= 1'b1;
                            state  <= ST_SUB_ACK;
                        end else begin
                            ptr    <= ptr + 1'b1;
                            sda_oe <= 1'b1;
                            state  <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        bitcnt <= '0;
                        if (rnw) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_SUB;
                        end
                    end
                end
                ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (evt.scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                        bitcnt <= '0;
                        state  <= ST_RMACK;
                    end else if (evt.scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                    end
                end
                ST_RMACK: begin
                    if (evt.scl_rise) begin
                        nack <= evt.sda;
                    end else if (evt.scl_fall) begin
                        if (nack) begin
                            state <= ST_IGNORE;
                        end else begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            bitcnt <= '0;
                            state  <= ST_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_start_restart_R9: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR) && !sda_oe);

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE) && !sda_oe);

    assert_ignore_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    assert_drive_window_R6: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> may_drive(state));

    assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr == $past(ptr) + 8'd1));

endmodule

// File: rtl/vid_cfg_regs.sv
module vid_cfg_regs
    import vid_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output vid_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.wss           <= '0;
            cfg.wss_en        <= 1'b0;
            cfg.burst_start   <= BURST_START_RST;
            cfg.burst_end     <= BURST_END_RST;
            cfg.colour_det_en <= 1'b0;
            cfg.field_seq_sel <= 1'b0;
        end else if (we) begin
            case (addr)
                SUB_WSS_LO: cfg.wss[7:0] <= wdata;
                SUB_WSS_HI: begin
                    cfg.wss[WSS_W-1:8] <= wdata[5:0];
                    cfg.wss_en         <= wdata[7];
                end
                SUB_BST: begin
                    cfg.burst_start   <= wdata[BURST_W-1:0];
                    cfg.colour_det_en <= wdata[6];
                end
                SUB_BEN: begin
                    cfg.burst_end     <= wdata[BURST_W-1:0];
                    cfg.field_seq_sel <= wdata[6];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            SUB_WSS_LO: rdata = cfg.wss[7:0];
            SUB_WSS_HI: rdata = {cfg.wss_en, 1'b0, cfg.wss[WSS_W-1:8]};
            SUB_BST:    rdata = {1'b0, cfg.colour_det_en, cfg.burst_start};
            SUB_BEN:    rdata = {1'b0, cfg.field_seq_sel, cfg.burst_end};
            default:    rdata = 8'h00;
        endcase
    end

    assert_reset_defaults_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg.burst_start == 6'd33) && (cfg.burst_end == 6'd29) &&
                       (cfg.wss == '0) && !cfg.wss_en &&
                       !cfg.colour_det_en && !cfg.field_seq_sel);

    assert_wss_lo_store_R8: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SUB_WSS_LO) |=> (cfg.wss[7:0] == $past(wdata)));

    assert_unmapped_inert_R10: assert property (@(posedge clk) disable iff (rst)
        (we && !is_mapped(addr)) |=> (cfg == $past(cfg)));

endmodule

// File: rtl/vid_enc_i2c_slave.sv
module vid_enc_i2c_slave
    import vid_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR_A  = 7'h44,
    parameter logic [6:0] DEV_ADDR_B  = 7'h46,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               addr_sel,
    output logic               sda_oe,
    output logic [WSS_W-1:0]   wss_word,
    output logic               wss_enable,
    output logic [BURST_W-1:0] burst_start,
    output logic [BURST_W-1:0] burst_end,
    output logic               colour_det_en,
    output logic               field_seq_sel
);
    bus_evt_t         evt;
    logic [PTR_W-1:0] ptr;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;
    vid_cfg_t         cfg;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_slave_fsm #(.DEV_ADDR_A(DEV_ADDR_A), .DEV_ADDR_B(DEV_ADDR_B)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    vid_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .addr  (ptr),
        .wdata (wr_data),
        .rdata (rd_data),
        .cfg   (cfg)
    );

    always_comb begin
        wss_word      = cfg.wss;
        wss_enable    = cfg.wss_en;
        burst_start   = cfg.burst_start;
        burst_end     = cfg.burst_end;
        colour_det_en = cfg.colour_det_en;
        field_seq_sel = cfg.field_seq_sel;
    end

endmodule

// File: tb/vid_enc_i2c_slave_test.sv
module vid_enc_i2c_slave_test;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_oe;
    logic        sda_bus;
    logic [13:0] wss_word;
    logic        wss_enable;
    logic [5:0]  burst_start;
    logic [5:0]  burst_end;
    logic        colour_det_en;
    logic        field_seq_sel;

    int checks = 0;
    int fails  = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    vid_enc_i2c_slave uut (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl_m),
        .sda_in        (sda_bus),
        .addr_sel      (addr_sel),
        .sda_oe        (sda_oe),
        .wss_word      (wss_word),
        .wss_enable    (wss_enable),
        .burst_start   (burst_start),
        .burst_end     (burst_end),
        .colour_det_en (colour_det_en),
        .field_seq_sel (field_seq_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b; hold();
        scl_m = 1'b1; hold();
        seen = sda_bus; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~m_ack, s);
    endtask

    task automatic t_reset();
        chk("R7 wss_word", wss_word, 0);
        chk("R7 wss_enable", wss_enable, 0);
        chk("R7 burst_start", burst_start, 33);
        chk("R7 burst_end", burst_end, 29);
        chk("R7 colour_det_en", colour_det_en, 0);
        chk("R7 field_seq_sel", field_seq_sel, 0);
        chk("R7 sda_oe", sda_oe, 0);
    endtask

    task automatic t_write_wss();
        logic a;
        addr_sel = 1'b0;
        bus_start();
        write_byte(8'h88, a); chk("R1 ack addr 44h", a, 1);
        write_byte(8'h26, a); chk("R3 ack subaddr", a, 1);
        write_byte(8'h5A, a); chk("R3 ack data", a, 1);
        write_byte(8'hE3, a); chk("R4 ack second data", a, 1);
        bus_stop();
        chk("R8 wss_word", wss_word, 14'h235A);
        chk("R8 wss_enable", wss_enable, 1);
        chk("R9 released after stop", sda_oe, 0);
    endtask

    task automatic t_burst_rw();
        logic a;
        logic [7:0] d;
        bus_start();
        write_byte(8'h88, a);
        write_byte(8'h28, a);
        write_byte(8'h45, a); chk("R3 ack 28h", a, 1);
        write_byte(8'h4A, a); chk("R4 ack 29h", a, 1);
        write_byte(8'h77, a); chk("R10 ack 2Ah", a, 1);
        chk("R8 burst_start", burst_start, 5);
        chk("R8 colour_det_en", colour_det_en, 1);
        chk("R8 burst_end", burst_end, 10);
        chk("R8 field_seq_sel", field_seq_sel, 1);
        chk("R10 wss untouched", wss_word, 14'h235A);
        bus_start();
        write_byte(8'h88, a);
        write_byte(8'h28, a);
        bus_start();
        write_byte(8'h89, a); chk("R9 repeated start read ack", a, 1);
        read_byte(1'b1, d);   chk("R5 read 28h", d, 8'h45);
        read_byte(1'b1, d);   chk("R5 read 29h", d, 8'h4A);
        read_byte(1'b0, d);   chk("R10 read 2Ah", d, 8'h00);
        chk("R6 released after nack", sda_oe, 0);
        write_byte(8'h00, a); chk("R6 silent after nack", a, 0);
        bus_stop();
    endtask

    task automatic t_read_cont();
        logic a;
        logic [7:0] d;
        bus_start();
        write_byte(8'h88, a);
        write_byte(8'h27, a);
        bus_stop();
        bus_start();
        write_byte(8'h89, a); chk("R5 read addr ack", a, 1);
        read_byte(1'b1, d);   chk("R5 read from pointer 27h", d, 8'hA3);
        read_byte(1'b0, d);   chk("R5 continue to 28h", d, 8'h45);
        bus_stop();
    endtask

    task automatic t_addr_sel();
        logic a;
        addr_sel = 1'b1;
        bus_start();
        write_byte(8'h88, a); chk("R2 nack 44h when sel=1", a, 0);
        write_byte(8'h26, a); chk("R2 ignored byte", a, 0);
        write_byte(8'h00, a); chk("R2 ignored data", a, 0);
        chk("R2 wss unchanged", wss_word, 14'h235A);
        bus_start();
        write_byte(8'h8C, a); chk("R1 ack 46h", a, 1);
        write_byte(8'h27, a);
        write_byte(8'h00, a);
        bus_stop();
        chk("R9 wss high after restart", wss_word, 14'h005A);
        chk("R9 enable cleared", wss_enable, 0);
    endtask

    task automatic t_wrap();
        logic a;
        logic all_ack = 1'b1;
        bus_start();
        write_byte(8'h8C, a);
        write_byte(8'hFF, a);
        write_byte(8'h99, a); chk("R4 ack at FFh", a, 1);
        for (int i = 0; i < 38; i++) begin
            write_byte(8'h00, a);
            all_ack &= a;
        end
        chk("R4 ack 00h..25h", all_ack, 1);
        write_byte(8'h34, a);
        write_byte(8'h05, a);
        bus_stop();
        chk("R4 wrap lands at 26h/27h", wss_word, 14'h0534);
        chk("R4 burst untouched by wrap", burst_start, 5);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_wss();
        t_burst_rw();
        t_read_cont();
        t_addr_sel();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule